// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives on-chip logic access to the 16-bit internal control registers of a serial-link PHY. The PHY sits behind a 32-bit control word and a 32-bit status word, and every transfer across them uses a four-phase strobe/acknowledge exchange. A client hands over one command at a time through a valid/ready port: a write or a read, a 16-bit register address and 16-bit write data. The block then runs the whole chain of handshake phases on its own and returns a done pulse with read data, or an error pulse.

A write loads the address and captures it, loads the data and captures it, and then pulses the write strobe. A read captures the address and then raises the read strobe, taking the data from the status word while that strobe is high. Every wait for the acknowledge has a limited number of polls, spaced a set number of clock cycles apart. If the acknowledge does not arrive in time, the whole command is abandoned. A nonzero write to the PHY's clock/reset register is a special case. The PHY cannot acknowledge that write, so its final strobe is fired without waiting.

Top module: `phy_cr_master`

## Requirements
- R1: The control word `ctrl_o` carries the field value in bits 15:0. The capture-address strobe is bit 16, capture-data is bit 17, write is bit 18 and read is bit 19. Bits 31:20 are zero, and at most one strobe bit is high at any time.
- R2: In the status word `stat_i`, bit 18 is the acknowledge and bits 15:0 are the PHY read data. No other status bit has any effect.
- R3: Each phase raises its strobe and holds it until a poll sees acknowledge = 1. It then drops the strobe and stays in the phase until a poll sees acknowledge = 0.
- R4: A write runs three phases in order. The first is capture-address with the field holding the address. The second is capture-data with the field holding the write data. The third is the write strobe with the field still holding the data.
- R5: A read runs capture-address and then the read strobe. `rdata_o` takes the status read data sampled while the read strobe and the acknowledge are both high, and it updates in the same cycle as `done_o`.
- R6: For a write of nonzero data to address `RST_REG_ADDR` (default 0x7F3F), the address and data phases run as usual. After them the write strobe is driven with the data for exactly one cycle and no acknowledge is awaited. `done_o` pulses in the next cycle. A write of zero data to that address is handled as an ordinary write.
- R7: Within a phase, the first poll falls in the phase's first cycle and later polls come every `POLL_CYCLES` cycles. If the `POLL_BUDGET`-th poll fails, `err_o` pulses in the following cycle and the command ends. The poll budget starts again at the beginning of every phase.
- R8: `req_ready_o` is high only in idle. From the accepting edge until the done or error pulse it is low, and requests presented while it is low are ignored.
- R9: After an error the block is idle with every strobe bit cleared. In idle, the acknowledge has no effect on any output.
- R10: `rdata_o` changes only in a cycle where `done_o` is high, and writes never change it.
- R11: `done_o` and `err_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command request |
| req_ready_o | output | 1 | High when idle and able to take a command |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | PHY register address |
| req_wdata_i | input | 16 | Write data |
| ctrl_o | output | 32 | Control word to the PHY (field and strobes) |
| stat_i | input | 32 | Status word from the PHY (acknowledge and read data) |
| done_o | output | 1 | Command completed |
| err_o | output | 1 | Command abandoned on acknowledge timeout |
| rdata_o | output | 16 | Data from the last completed read |

## Verification
A command is accepted on the rising edge on which `req_valid_i` and `req_ready_o` are both high. The first strobe is visible in the following cycle. With an acknowledge that never rises, `err_o` is visible (POLL_BUDGET-1)·POLL_CYCLES+2 cycles after that acceptance edge. With an acknowledge stuck high, it comes one cycle later, because the budget starts again for the falling half. On the clock/reset-register path, `done_o` follows the single write-strobe cycle by exactly one cycle. The bench counts falling edges from the edge on which it drives a request and compares those counts against the values above. For handshakes of random latency, it waits for the completion pulse under a bound and then checks the phase log it recorded and the returned data.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  localparam int unsigned CR_FW      = 16;
  localparam int unsigned CR_WW      = 32;
  localparam int unsigned CR_NSTB    = 4;
  localparam int unsigned STB_LSB    = 16;
  localparam int unsigned ACK_BIT    = 18;

  localparam logic [CR_NSTB-1:0] STB_CAP_ADDR = 4'b0001;
  localparam logic [CR_NSTB-1:0] STB_CAP_DATA = 4'b0010;
  localparam logic [CR_NSTB-1:0] STB_WRITE    = 4'b0100;
  localparam logic [CR_NSTB-1:0] STB_READ     = 4'b1000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_HI, ST_ADR_LO,
    ST_DAT_HI, ST_DAT_LO,
    ST_WR_HI,  ST_WR_LO,
    ST_RD_HI,  ST_RD_LO,
    ST_RST_FIRE
  } cr_state_e;
endpackage

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int unsigned INTERVAL = 10000,
  parameter int unsigned BUDGET   = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic miss_i,
  output logic poll_o,
  output logic expire_o
);
  localparam int unsigned IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int unsigned BW = (BUDGET > 1) ? $clog2(BUDGET) : 1;

  logic [IW-1:0] intv_q;
  logic [BW-1:0] polls_q;

  assign poll_o   = (intv_q == '0);
  assign expire_o = poll_o && miss_i && (polls_q == BW'(BUDGET - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intv_q  <= '0;
      polls_q <= '0;
    end else if (restart_i) begin
      intv_q  <= '0;
      polls_q <= '0;
    end else if (poll_o && miss_i) begin
      intv_q  <= IW'(INTERVAL - 1);
      polls_q <= polls_q + 1'b1;
    end else if (intv_q != '0) begin
      intv_q  <= intv_q - 1'b1;
    end
  end
endmodule

// File: rtl/phy_cr_fsm.sv
module phy_cr_fsm
  import phy_cr_pkg::*;
#(
  parameter logic [CR_FW-1:0] RST_REG_ADDR = 16'h7F3F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CR_FW-1:0] req_addr_i,
  input  logic [CR_FW-1:0] req_wdata_i,
  output logic             req_ready_o,
  input  logic             ack_i,
  input  logic [CR_FW-1:0] rd_i,
  input  logic             poll_i,
  input  logic             expire_i,
  output logic             restart_o,
  output logic             miss_o,
  output logic [CR_WW-1:0] ctrl_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CR_FW-1:0] rdata_o
);
  cr_state_e          state_q;
  logic [CR_FW-1:0]   field_q, wdata_q, shadow_q, rdata_q;
  logic               write_q, rst_hit_q, done_q, err_q;
  logic               waiting, want_hi, hit;
  logic [CR_NSTB-1:0] stb;

  always_comb begin
    stb     = '0;
    want_hi = 1'b0;
    waiting = 1'b1;
    unique case (state_q)
      ST_IDLE:     waiting = 1'b0;
      ST_RST_FIRE: begin waiting = 1'b0; stb = STB_WRITE; end
      ST_ADR_HI:   begin want_hi = 1'b1; stb = STB_CAP_ADDR; end
      ST_DAT_HI:   begin want_hi = 1'b1; stb = STB_CAP_DATA; end
      ST_WR_HI:    begin want_hi = 1'b1; stb = STB_WRITE; end
      ST_RD_HI:    begin want_hi = 1'b1; stb = STB_READ; end
      default:     ;
    endcase
  end

  assign miss_o      = waiting && (ack_i != want_hi);
  assign hit         = waiting && poll_i && (ack_i == want_hi);
  assign restart_o   = !waiting || hit;
  assign req_ready_o = (state_q == ST_IDLE);
  assign ctrl_o      = {{(CR_WW - STB_LSB - CR_NSTB){1'b0}}, stb, field_q};
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      field_q   <= '0;
      wdata_q   <= '0;
      shadow_q  <= '0;
      rdata_q   <= '0;
      write_q   <= 1'b0;
      rst_hit_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_valid_i) begin
          field_q   <= req_addr_i;
          wdata_q   <= req_wdata_i;
          write_q   <= req_write_i;
          rst_hit_q <= (req_addr_i == RST_REG_ADDR) && (req_wdata_i != '0);
          state_q   <= ST_ADR_HI;
        end
      end else if (state_q == ST_RST_FIRE) begin
        done_q  <= 1'b1;
        state_q <= ST_IDLE;
      end else if (expire_i) begin
        err_q   <= 1'b1;
        state_q <= ST_IDLE;
      end else if (hit) begin
        unique case (state_q)
          ST_ADR_HI: state_q <= ST_ADR_LO;
          ST_ADR_LO: begin
            if (write_q) begin
              field_q <= wdata_q;
              state_q <= ST_DAT_HI;
            end else begin
              state_q <= ST_RD_HI;
            end
          end
          ST_DAT_HI: state_q <= ST_DAT_LO;
          ST_DAT_LO: state_q <= rst_hit_q ? ST_RST_FIRE : ST_WR_HI;
          ST_WR_HI:  state_q <= ST_WR_LO;
          ST_RD_HI: begin
            shadow_q <= rd_i;
            state_q  <= ST_RD_LO;
          end
          ST_WR_LO: begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          ST_RD_LO: begin
            rdata_q <= shadow_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned      POLL_CYCLES  = 10000,
  parameter int unsigned      POLL_BUDGET  = 5000,
  parameter logic [15:0]      RST_REG_ADDR = 16'h7F3F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [15:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic [31:0] ctrl_o,
  input  logic [31:0] stat_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o
);
  logic poll, expire, restart, miss;
  logic unused_stat;

  assign unused_stat = ^{stat_i[CR_WW-1:ACK_BIT+1], stat_i[ACK_BIT-1:CR_FW]};

  phy_cr_poll_timer #(
    .INTERVAL (POLL_CYCLES),
    .BUDGET   (POLL_BUDGET)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .miss_i    (miss),
    .poll_o    (poll),
    .expire_o  (expire)
  );

  phy_cr_fsm #(
    .RST_REG_ADDR (RST_REG_ADDR)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .ack_i       (stat_i[ACK_BIT]),
    .rd_i        (stat_i[CR_FW-1:0]),
    .poll_i      (poll),
    .expire_i    (expire),
    .restart_o   (restart),
    .miss_o      (miss),
    .ctrl_o      (ctrl_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] ctrl_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o
);
  // R1
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_o[19:16]) && (ctrl_o[31:20] == 12'h000));

  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R9
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ctrl_o[19:16] == 4'b0000) && req_ready_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
endmodule

bind phy_cr_master phy_cr_master_chk u_chk (.*);

// File: tb/phy_cr_master_bench.sv
module phy_cr_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;
  localparam int B = 4;
  localparam logic [15:0] RST_ADDR = 16'h7F3F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, err;
  logic [31:0] ctrl, stat;
  logic [15:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cr_master #(.POLL_CYCLES(P), .POLL_BUDGET(B), .RST_REG_ADDR(RST_ADDR)) u_phy_cr_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ctrl_o(ctrl), .stat_i(stat), .done_o(done), .err_o(err), .rdata_o(rdata));

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  // PHY model
  int          mode = 0;        // 0 live, 1 stuck low, 2 stuck high, 3 random
  int          lat = 0, lat_cnt = 0;
  logic        ack = 1'b0;
  logic [3:0]  prev_stb = '0;
  logic [15:0] m_addr = '0;
  logic [15:0] mem [16];
  // monitor log
  int          log_n = 0, wr_hi_n = 0, done_cyc = 0, err_cyc = 0;
  int          log_bit [8];
  logic [15:0] log_fld [8];
  int          log_cyc [8];
  logic [15:0] exp_mem [16];

  assign stat = {13'h0, ack, 2'b00, mem[m_addr[3:0]]};

  always @(negedge clk) begin
    cyc++;
    if (done) done_cyc = cyc;
    if (err) err_cyc = cyc;
    if (ctrl[18]) wr_hi_n++;
    for (int k = 0; k < 4; k++) begin
      if (ctrl[16+k] && !prev_stb[k]) begin
        if (log_n < 8) begin
          log_bit[log_n] = 16 + k;
          log_fld[log_n] = ctrl[15:0];
          log_cyc[log_n] = cyc;
        end
        log_n++;
        if (k == 0) m_addr = ctrl[15:0];
        if (k == 2) mem[m_addr[3:0]] = ctrl[15:0];
      end
    end
    prev_stb = ctrl[19:16];
    case (mode)
      1: ack = 1'b0;
      2: ack = 1'b1;
      3: ack = 1'($urandom % 2);
      default: begin
        if (ack != (|ctrl[19:16])) begin
          if (lat_cnt >= lat) begin ack = |ctrl[19:16]; lat_cnt = 0; end
          else lat_cnt++;
        end else lat_cnt = 0;
      end
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    return exp_mem[a[3:0]];
  endfunction

  // returns 1 = done, 2 = error, 0 = hung
  task automatic run_op(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input int hold, output int res, output int acc);
    @(negedge clk); #1;
    log_n = 0; wr_hi_n = 0;
    acc = cyc;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); #1;
      req_addr = 16'(~a); req_wdata = 16'(~d); req_write = !w;
      // R8 ready low while busy, extra requests ignored
      if (hold > 1) chk(!req_ready, "R8 busy ready", 32'(req_ready), 0);
    end
    req_valid = 1'b0;
    res = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (done) begin res = 1; break; end
      if (err)  begin res = 2; break; end
    end
    #1;
    if (res == 1 && w) exp_mem[a[3:0]] = d;
  endtask

  task automatic check_write(input logic [15:0] a, input logic [15:0] d, input int res);
    chk(res == 1, "R4 write done", 32'(res), 1);
    chk(log_n == 3 && log_bit[0] == 16 && log_bit[1] == 17 && log_bit[2] == 18,
        "R4 write phase order", 32'(log_n), 3);
    chk(log_fld[0] == a && log_fld[1] == d && log_fld[2] == d,
        "R4 write fields", {log_fld[0], log_fld[1]}, {a, d});
  endtask

  task automatic check_read(input logic [15:0] a, input int res);
    chk(res == 1, "R5 read done", 32'(res), 1);
    chk(log_n == 2 && log_bit[0] == 16 && log_bit[1] == 19 && log_fld[0] == a,
        "R5 read phase order", 32'(log_n), 2);
    chk(rdata == exp_read(a), "R5 R2 read data", 32'(rdata), 32'(exp_read(a)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int res, acc;
    logic [15:0] a, d, held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R8 reset state
    chk(req_ready && ctrl == 32'h0 && !done && !err && rdata == 16'h0,
        "R1 R8 reset state", ctrl, 0);

    // R3 R4 directed write, slow ack
    lat = 4;
    run_op(1'b1, 16'h0005, 16'hA5A5, 1, res, acc);
    check_write(16'h0005, 16'hA5A5, res);
    chk(wr_hi_n >= 2, "R3 strobe held until ack", 32'(wr_hi_n), 2);
    // R11 pulse width
    @(negedge clk);
    chk(!done && !err, "R11 done single cycle", 32'(done), 0);

    // R5 R2 directed read
    lat = 0;
    run_op(1'b0, 16'h0005, 16'h0, 1, res, acc);
    check_read(16'h0005, res);

    // R8 busy requests ignored
    lat = 2;
    run_op(1'b1, 16'h0009, 16'h1234, 4, res, acc);
    check_write(16'h0009, 16'h1234, res);

    // random mix
    for (int t = 0; t < 40; t++) begin
      lat = $urandom % 6;
      a = 16'($urandom);
      if (a == RST_ADDR) a = 16'h0001;
      d = 16'($urandom);
      repeat (8) @(negedge clk);
      if ($urandom % 2) begin
        run_op(1'b1, a, d, 1, res, acc);
        check_write(a, d, res);
      end else begin
        run_op(1'b0, a, 16'h0, 1, res, acc);
        check_read(a, res);
      end
    end

    // R10 read data held across writes
    lat = 1;
    repeat (8) @(negedge clk);
    run_op(1'b0, 16'h0009, 16'h0, 1, res, acc);
    held = rdata;
    repeat (8) @(negedge clk);
    run_op(1'b1, 16'h0009, 16'hBEEF, 1, res, acc);
    repeat (8) @(negedge clk);
    run_op(1'b1, 16'h0003, 16'h7777, 1, res, acc);
    chk(rdata == held, "R10 rdata held after writes", 32'(rdata), 32'(held));

    // R6 reset register nonzero write
    lat = 1;
    repeat (8) @(negedge clk);
    run_op(1'b1, RST_ADDR, 16'h0001, 1, res, acc);
    chk(res == 1 && log_n == 3 && log_bit[2] == 18 && log_fld[2] == 16'h0001,
        "R6 reset write strobe with data", 32'(log_n), 3);
    chk(wr_hi_n == 1, "R6 write strobe one cycle", 32'(wr_hi_n), 1);
    chk(done_cyc == log_cyc[2] + 1, "R6 done next cycle", 32'(done_cyc), 32'(log_cyc[2] + 1));

    // R6 zero data to reset register is an ordinary write
    lat = 3;
    repeat (10) @(negedge clk);
    run_op(1'b1, RST_ADDR, 16'h0000, 1, res, acc);
    check_write(RST_ADDR, 16'h0000, res);
    chk(wr_hi_n >= 2, "R6 zero write waits for ack", 32'(wr_hi_n), 2);

    // R7 timeout, ack stuck low
    repeat (10) @(negedge clk);
    mode = 1;
    run_op(1'b1, 16'h0002, 16'h5555, 1, res, acc);
    chk(res == 2, "R7 timeout error", 32'(res), 2);
    chk(err_cyc - acc == (B-1)*P + 2, "R7 stuck-low error cycle",
        32'(err_cyc - acc), 32'((B-1)*P + 2));
    chk(ctrl[19:16] == 4'h0 && req_ready, "R9 strobes clear after error", ctrl, 0);

    // R7 budget reloads per phase, ack stuck high
    repeat (4) @(negedge clk);
    mode = 2;
    run_op(1'b0, 16'h0002, 16'h0, 1, res, acc);
    chk(res == 2, "R7 stuck-high error", 32'(res), 2);
    chk(err_cyc - acc == (B-1)*P + 3, "R7 stuck-high error cycle",
        32'(err_cyc - acc), 32'((B-1)*P + 3));

    // R9 ack ignored in idle
    mode = 3;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (ctrl[19:16] != 4'h0 || done || err || !req_ready) quiet = 1'b0;
      end
      chk(quiet, "R9 idle ignores ack", ctrl, 0);
    end
    mode = 0;
    ack = 1'b0;

    // recovery after error
    lat = 0;
    repeat (4) @(negedge clk);
    run_op(1'b0, 16'h0005, 16'h0, 1, res, acc);
    check_read(16'h0005, res);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule